// File: doc/BRIEF.md
# Hashed Binary Tree Walker

This controller moves a batch of walkers through a complete binary tree that sits, in level order, in a word-addressed memory. It uses one memory port. A start pulse makes it fetch a seven-word header at address zero. The header gives the number of rounds, the number of nodes, the batch size and the base addresses of three arrays: node values, walker indices and walker values.

Each round visits every walker in ascending order, one at a time. For each walker the controller reads its index and its value, then the value of the node at that index. It mixes the walker value with the node value through a fixed six-stage 32-bit hash and writes the result back. The parity of the result picks the left or the right child. An index that would fall past the last node goes back to the root. The new index is written back.

The controller has nine states: `S_IDLE`, `S_READ_HDR`, `S_READ_IDX`, `S_READ_VAL`, `S_READ_NODE`, `S_HASH_WAIT`, `S_WRITE_VAL`, `S_WRITE_IDX` and `S_DONE`. Its transitions are:
- IDLE→READ_HDR on start.
- READ_HDR→READ_IDX after the seventh header word arrives.
- READ_HDR→DONE instead when rounds or batch is zero.
- READ_IDX→READ_VAL→READ_NODE→HASH_WAIT→WRITE_VAL→WRITE_IDX, unconditionally.
- WRITE_IDX→READ_IDX for the next walker.
- WRITE_IDX→DONE after the last walker of the last round.
- DONE→READ_HDR on start.

Top module: `tree_walker`

## Requirements
- R1: After reset, `done` is low and neither `mem_rd_en` nor `mem_wr_en` is asserted until a start pulse.
- R2: Start is accepted in the idle and finished states. After start, the block reads addresses 0 to 6 on consecutive cycles, one per cycle. The header words are used as follows:
  - word 0: round count
  - word 1: node count
  - word 2: batch size
  - word 3: read but not used
  - word 4: node-value base
  - word 5: index base
  - word 6: value base
- R3: One step sets val to H(val xor node[idx]). H applies six stages in this order. Each stage sets a := g(f(a, K), a shifted by S), all modulo 2^32. The stages, written as (f, K, g, shift), are:
  - (add, 0x7ED55D16, add, left 12)
  - (xor, 0xC761C23C, xor, right 19)
  - (add, 0x165667B1, add, left 5)
  - (add, 0xD3A2646C, xor, left 9)
  - (add, 0xFD7046C5, add, left 3)
  - (xor, 0xB55A4F09, xor, right 16)
- R4: After a step, the next index is 2*idx+1 when the new val is even and 2*idx+2 when it is odd.
- R5: A next index greater than or equal to the node count is replaced by 0. A written index is therefore always below the node count, or zero.
- R6: Each round processes walkers 0 to batch-1 in order, and the batch is repeated for the given number of rounds. The updated val and idx are written back to `value base + walker` and `index base + walker`. The final arrays equal those of a sequential model.
- R7: When the round count or the batch size is zero, `done` rises and no memory write takes place.
- R8: `done` stays high while the block is finished and no start arrives, and the block makes no memory access in that state. A start in that state runs the whole job again on the current memory contents.
- R9: Read and write strobes are never active in the same cycle. Read data is taken one cycle after the read strobe. Addresses wrap modulo 2^ADDR_W.
- R10: A start pulse while a run is in progress has no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Single-cycle run request |
| done | output | 1 | High once the run has finished |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the read strobe |

## Verification
The bench runs trees of height 0, 2 and 3 with several rounds and compares the final index and value arrays with its own model.
- The height-0 and height-3 cases force repeated wraps to the root. A design that compared against the height or used a strict greater-than test would leave walkers on indices past the tree.
- A hash stage with the wrong operator or shift corrupts every value from the first step on.
- Swapping the parity test sends walkers down the mirrored path and corrupts the index array.
- With zero rounds or a zero batch, a design that entered the walk anyway would write to memory.
- A second start mid-run would restart the job and apply extra rounds.
- A restart from the finished state must apply the rounds again on top of the earlier results, and a controller that kept stale counters would not.

// File: rtl/walk_pkg.sv
package walk_pkg;

    localparam int WORD_W     = 32;
    localparam int MIX_STAGES = 6;
    localparam int HDR_WORDS  = 7;

    typedef enum logic [3:0] {
        S_IDLE,
        S_READ_HDR,
        S_READ_IDX,
        S_READ_VAL,
        S_READ_NODE,
        S_HASH_WAIT,
        S_WRITE_VAL,
        S_WRITE_IDX,
        S_DONE
    } walk_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] k;
        logic              add_in;
        logic              add_out;
        logic              left;
        logic [4:0]        sh;
    } mix_cfg_t;

    // Stage order is part of the function and must not be permuted.
    function automatic mix_cfg_t mix_cfg(input int s);
        mix_cfg_t c;
        case (s)
            0:       c = '{k: 32'h7ED55D16, add_in: 1'b1, add_out: 1'b1, left: 1'b1, sh: 5'd12};
            1:       c = '{k: 32'hC761C23C, add_in: 1'b0, add_out: 1'b0, left: 1'b0, sh: 5'd19};
            2:       c = '{k: 32'h165667B1, add_in: 1'b1, add_out: 1'b1, left: 1'b1, sh: 5'd5};
            3:       c = '{k: 32'hD3A2646C, add_in: 1'b1, add_out: 1'b0, left: 1'b1, sh: 5'd9};
            4:       c = '{k: 32'hFD7046C5, add_in: 1'b1, add_out: 1'b1, left: 1'b1, sh: 5'd3};
            default: c = '{k: 32'hB55A4F09, add_in: 1'b0, add_out: 1'b0, left: 1'b0, sh: 5'd16};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/walk_hash_stage.sv
module walk_hash_stage
    import walk_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [WORD_W-1:0] x,
    output logic [WORD_W-1:0] y
);
    localparam mix_cfg_t CFG = mix_cfg(IDX);

    logic [WORD_W-1:0] mixed;
    logic [WORD_W-1:0] shifted;

    always_comb begin
        mixed   = CFG.add_in ? (x + CFG.k) : (x ^ CFG.k);
        shifted = CFG.left ? (x << CFG.sh) : (x >> CFG.sh);
        y       = CFG.add_out ? (mixed + shifted) : (mixed ^ shifted);
    end
endmodule

// File: rtl/walk_hash.sv
module walk_hash
    import walk_pkg::*;
(
    input  logic [WORD_W-1:0] din,
    output logic [WORD_W-1:0] dout
);
    logic [WORD_W-1:0] chain [MIX_STAGES+1];

    assign chain[0] = din;

    for (genvar g = 0; g < MIX_STAGES; g++) begin : g_stage
        walk_hash_stage #(.IDX(g)) stage_i (
            .x (chain[g]),
            .y (chain[g+1])
        );
    end

    assign dout = chain[MIX_STAGES];
endmodule

// File: rtl/tree_walker.sv
module tree_walker
    import walk_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam logic [2:0] HDR_LAST = 3'(HDR_WORDS);

    walk_state_e       state_q, state_d;
    logic [2:0]        hdr_cnt;
    logic [WORD_W-1:0] rounds_q, nodes_q, batch_q;
    logic [ADDR_W-1:0] nbase_q, ibase_q, vbase_q;
    logic [WORD_W-1:0] walker_q, round_q;
    logic [WORD_W-1:0] idx_q, val_q;
    logic [WORD_W-1:0] hash_out;
    logic [WORD_W:0]   child;
    logic [WORD_W-1:0] next_idx;
    logic              last_walker, last_round;

    walk_hash hash_i (
        .din  (val_q ^ mem_rdata),
        .dout (hash_out)
    );

    always_comb begin
        child       = {idx_q, 1'b0} + (val_q[0] ? (WORD_W+1)'(2) : (WORD_W+1)'(1));
        next_idx    = (child >= {1'b0, nodes_q}) ? '0 : child[WORD_W-1:0];
        last_walker = (walker_q == batch_q - 1'b1);
        last_round  = (round_q == rounds_q - 1'b1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:      if (start) state_d = S_READ_HDR;
            S_READ_HDR:  if (hdr_cnt == HDR_LAST)
                             state_d = (rounds_q == '0 || batch_q == '0) ? S_DONE : S_READ_IDX;
            S_READ_IDX:  state_d = S_READ_VAL;
            S_READ_VAL:  state_d = S_READ_NODE;
            S_READ_NODE: state_d = S_HASH_WAIT;
            S_HASH_WAIT: state_d = S_WRITE_VAL;
            S_WRITE_VAL: state_d = S_WRITE_IDX;
            S_WRITE_IDX: state_d = (last_walker && last_round) ? S_DONE : S_READ_IDX;
            S_DONE:      if (start) state_d = S_READ_HDR;
            default:     state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd_en = 1'b0;
        mem_wr_en = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        done      = 1'b0;
        unique case (state_q)
            S_READ_HDR: begin
                mem_rd_en = (hdr_cnt != HDR_LAST);
                mem_addr  = ADDR_W'(hdr_cnt);
            end
            S_READ_IDX: begin
                mem_rd_en = 1'b1;
                mem_addr  = ibase_q + walker_q[ADDR_W-1:0];
            end
            S_READ_VAL: begin
                mem_rd_en = 1'b1;
                mem_addr  = vbase_q + walker_q[ADDR_W-1:0];
            end
            S_READ_NODE: begin
                mem_rd_en = 1'b1;
                mem_addr  = nbase_q + idx_q[ADDR_W-1:0];
            end
            S_WRITE_VAL: begin
                mem_wr_en = 1'b1;
                mem_addr  = vbase_q + walker_q[ADDR_W-1:0];
                mem_wdata = val_q;
            end
            S_WRITE_IDX: begin
                mem_wr_en = 1'b1;
                mem_addr  = ibase_q + walker_q[ADDR_W-1:0];
                mem_wdata = idx_q;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_cnt  <= '0;
            rounds_q <= '0;
            nodes_q  <= '0;
            batch_q  <= '0;
            nbase_q  <= '0;
            ibase_q  <= '0;
            vbase_q  <= '0;
            walker_q <= '0;
            round_q  <= '0;
            idx_q    <= '0;
            val_q    <= '0;
        end else begin
            unique case (state_q)
                S_IDLE, S_DONE: hdr_cnt <= '0;
                S_READ_HDR: begin
                    hdr_cnt <= hdr_cnt + 3'd1;
                    case (hdr_cnt)
                        3'd1: rounds_q <= mem_rdata;
                        3'd2: nodes_q  <= mem_rdata;
                        3'd3: batch_q  <= mem_rdata;
                        3'd5: nbase_q  <= mem_rdata[ADDR_W-1:0];
                        3'd6: ibase_q  <= mem_rdata[ADDR_W-1:0];
                        3'd7: begin
                            vbase_q  <= mem_rdata[ADDR_W-1:0];
                            walker_q <= '0;
                            round_q  <= '0;
                        end
                        default: ;
                    endcase
                end
                S_READ_IDX:  ;
                S_READ_VAL:  idx_q <= mem_rdata;
                S_READ_NODE: val_q <= mem_rdata;
                S_HASH_WAIT: val_q <= hash_out;
                S_WRITE_VAL: idx_q <= next_idx;
                S_WRITE_IDX: begin
                    if (last_walker) begin
                        walker_q <= '0;
                        round_q  <= round_q + 1'b1;
                    end else begin
                        walker_q <= walker_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/walk_chk.sv
module walk_chk
    import walk_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              done,
    input logic              mem_rd_en,
    input logic              mem_wr_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input walk_state_e       st,
    input logic [WORD_W-1:0] nodes
);
    assert_port_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    assert_hdr_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && start) |=> (mem_rd_en && mem_addr == '0));

    assert_idx_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_WRITE_IDX) |-> (mem_wr_en && (mem_wdata < nodes || mem_wdata == '0)));

    assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_rd_en && !mem_wr_en));
endmodule

bind tree_walker walk_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .mem_wr_en (mem_wr_en),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .st        (state_q),
    .nodes     (nodes_q)
);

// File: tb/tree_walker_tb_top.sv
module tree_walker_tb_top;
    localparam int AW = 10;
    localparam int MEM_WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          done, mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = '0;

    logic [31:0]   mem [MEM_WORDS];
    logic          tb_we = 1'b0;
    logic [AW-1:0] tb_a = '0;
    logic [31:0]   tb_d = '0;

    int n_checks = 0;
    int n_fail = 0;
    int wr_cnt = 0;
    int clash_cnt = 0;

    int cur_nodes, cur_batch, cur_rounds, nb, ib, vb;
    logic [31:0] tree [64];
    logic [31:0] e_idx [32];
    logic [31:0] e_val [32];

    always #2.5 clk = ~clk;

    tree_walker #(.ADDR_W(AW)) dut_i (
        .clk (clk), .rst_n (rst_n), .start (start), .done (done),
        .mem_rd_en (mem_rd_en), .mem_wr_en (mem_wr_en), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    always @(posedge clk) begin
        if (tb_we) mem[tb_a] <= tb_d;
        else if (mem_wr_en) mem[mem_addr] <= mem_wdata;
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
        if (mem_wr_en) wr_cnt <= wr_cnt + 1;
        if (mem_wr_en && mem_rd_en) clash_cnt <= clash_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_hash(input logic [31:0] a0);
        logic [31:0] a, p, q;
        a = a0;
        for (int s = 0; s < 6; s++) begin
            case (s)
                0: begin p = a + 32'h7ED55D16; q = a << 12; a = p + q; end
                1: begin p = a ^ 32'hC761C23C; q = a >> 19; a = p ^ q; end
                2: begin p = a + 32'h165667B1; q = a << 5;  a = p + q; end
                3: begin p = a + 32'hD3A2646C; q = a << 9;  a = p ^ q; end
                4: begin p = a + 32'hFD7046C5; q = a << 3;  a = p + q; end
                default: begin p = a ^ 32'hB55A4F09; q = a >> 16; a = p ^ q; end
            endcase
        end
        return a;
    endfunction

    task automatic poke(input int a, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_a = AW'(a); tb_d = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic load_problem(input int height, input int batch, input int rounds);
        cur_nodes = (2 << height) - 1;
        cur_batch = batch;
        cur_rounds = rounds;
        nb = 8;
        ib = nb + cur_nodes;
        vb = ib + batch + 3;
        poke(0, rounds); poke(1, cur_nodes); poke(2, batch); poke(3, height);
        poke(4, nb); poke(5, ib); poke(6, vb);
        for (int n = 0; n < cur_nodes; n++) begin
            tree[n] = $urandom & 32'h3FFF_FFFF;
            poke(nb + n, tree[n]);
        end
        for (int w = 0; w < batch; w++) begin
            e_idx[w] = '0;
            e_val[w] = $urandom & 32'h3FFF_FFFF;
            poke(ib + w, 0);
            poke(vb + w, e_val[w]);
        end
    endtask

    task automatic model_run();
        logic [31:0] v, n;
        for (int r = 0; r < cur_rounds; r++)
            for (int w = 0; w < cur_batch; w++) begin
                v = ref_hash(e_val[w] ^ tree[e_idx[w]]);
                n = 2 * e_idx[w] + (v[0] ? 32'd2 : 32'd1);
                if (n >= 32'(cur_nodes)) n = '0;
                e_val[w] = v;
                e_idx[w] = n;
            end
    endtask

    task automatic run_dut(input bit check_hdr, input bit poke_mid);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        if (check_hdr)
            for (int k = 0; k < 7; k++) begin
                chk(mem_rd_en && mem_addr == AW'(k), "R2 header read order", 32'(mem_addr), k);
                @(negedge clk);
            end
        if (poke_mid) begin
            repeat (20) @(negedge clk);
            start = 1'b1;
            @(negedge clk); start = 1'b0;
        end
        for (int c = 0; c < 50000 && !done; c++) @(negedge clk);
        chk(done, "R6 run finished", 32'(done), 1);
    endtask

    task automatic compare_arrays(input string tag);
        for (int w = 0; w < cur_batch; w++) begin
            chk(mem[ib + w] == e_idx[w], {tag, " R4/R5 index"}, mem[ib + w], e_idx[w]);
            chk(mem[vb + w] == e_val[w], {tag, " R3 value"}, mem[vb + w], e_val[w]);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!done && !mem_rd_en && !mem_wr_en, "R1 in reset", {29'd0, done, mem_rd_en, mem_wr_en}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !mem_rd_en && !mem_wr_en, "R1 after reset", {29'd0, done, mem_rd_en, mem_wr_en}, 0);
    endtask

    task automatic t_basic();
        load_problem(2, 4, 3);
        model_run();
        run_dut(1'b1, 1'b0);
        compare_arrays("h2");
    endtask

    task automatic t_deep_wrap();
        load_problem(3, 5, 10);
        model_run();
        run_dut(1'b0, 1'b0);
        compare_arrays("h3 R6");
    endtask

    task automatic t_single_node();
        load_problem(0, 3, 4);
        model_run();
        run_dut(1'b0, 1'b0);
        for (int w = 0; w < cur_batch; w++)
            chk(mem[ib + w] == 0, "R5 single node wraps", mem[ib + w], 0);
        compare_arrays("h0");
    endtask

    task automatic t_done_hold_restart();
        int w0;
        load_problem(2, 3, 2);
        model_run();
        run_dut(1'b0, 1'b0);
        w0 = wr_cnt;
        repeat (6) @(negedge clk);
        chk(done, "R8 done held", 32'(done), 1);
        chk(wr_cnt == w0 && !mem_rd_en, "R8 quiet when done", wr_cnt - w0, 0);
        model_run();
        run_dut(1'b0, 1'b0);
        compare_arrays("R8 restart");
    endtask

    task automatic t_start_busy();
        load_problem(2, 4, 2);
        model_run();
        run_dut(1'b0, 1'b1);
        compare_arrays("R10 start ignored");
    endtask

    task automatic t_zero_rounds();
        int w0;
        load_problem(2, 4, 0);
        w0 = wr_cnt;
        run_dut(1'b0, 1'b0);
        chk(wr_cnt == w0, "R7 no writes, zero rounds", wr_cnt - w0, 0);
        compare_arrays("R7 unchanged");
    endtask

    task automatic t_zero_batch();
        int w0;
        load_problem(1, 0, 3);
        w0 = wr_cnt;
        run_dut(1'b0, 1'b0);
        chk(wr_cnt == w0, "R7 no writes, zero batch", wr_cnt - w0, 0);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_deep_wrap();
        t_single_node();
        t_done_hold_restart();
        t_start_busy();
        t_zero_rounds();
        t_zero_batch();
        chk(clash_cnt == 0, "R9 read and write together", clash_cnt, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule